// File: doc/BRIEF.md
# Receive Drop Event Counter Register

This block tallies two kinds of lost receive frames and presents both tallies in a single 32-bit read-only status word. One counter records frames discarded because no receive buffer was free; the other records frames lost when the receive FIFO overflowed. Each source arrives as a one-cycle pulse from neighbouring logic.

Each counter carries a sticky flag. The flag sets when an event arrives while the counter already holds its largest value, so software can tell that the true count is at least full scale. A read strobe returns the word as it stands in that cycle and clears both counters and both flags. An event that coincides with the read is counted into the cleared counter, so no event is lost. A parameter chooses whether a counter at full scale wraps to zero (the default) or holds at its maximum.

Top module: `rx_miss_cnt`

## Requirements
- R1: After reset the status word reads 0x00000000.
- R2: Each cycle with `miss_evt_i` high and no read adds one to the buffer-miss count in bits 15:0.
- R3: Each cycle with `fovf_evt_i` high and no read adds one to the FIFO-overflow count in bits 27:17.
- R4: An event while a count is at full scale sets its flag (bit 16 for the buffer-miss count, bit 28 for the FIFO-overflow count), and the flag then stays set until a read, even as more events arrive.
- R5: In the default wrap mode a count at full scale returns to zero on its next event.
- R6: In saturate mode a count at full scale holds at full scale on further events, while its flag still sets.
- R7: In a cycle with `rd_i` high, `status_o` shows the current counts and flags; in the next cycle both counts and both flags are zero unless R8 applies.
- R8: An event in the same cycle as a read leaves its count at one in the next cycle, with its flag clear.
- R9: Bits 31:29 of the status word always read zero.
- R10: The two counters are independent: events on both inputs in the same cycle advance both counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| miss_evt_i | input | 1 | One-cycle pulse: frame dropped for lack of a receive buffer |
| fovf_evt_i | input | 1 | One-cycle pulse: frame lost to receive FIFO overflow |
| rd_i | input | 1 | Read strobe: capture the word this cycle, clear afterwards |
| status_o | output | 32 | Packed counts and sticky flags |

## Verification
The bench builds the block twice. One instance uses the defaults (16-bit and 11-bit counts, wrap mode), so that both counts can be driven right through full scale to show wrap and flag setting at the positions software expects. The second uses a 4-bit and a 3-bit count in saturate mode, which brings saturation, the sticky flags under continued events and their clearing on read within a few dozen cycles.

// File: rtl/rx_miss_pkg.sv
package rx_miss_pkg;

  typedef enum logic {
    CNT_WRAP     = 1'b0,
    CNT_SATURATE = 1'b1
  } ovf_mode_e;

  localparam int unsigned STATUS_W = 32;

  // Bits used by the packed layout: count, flag, count, flag.
  function automatic int unsigned used_bits(input int unsigned a_w, input int unsigned b_w);
    return a_w + 1 + b_w + 1;
  endfunction

endpackage

// File: rtl/rx_miss_rst_sync.sv
module rx_miss_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/rx_evt_counter.sv
module rx_evt_counter
  import rx_miss_pkg::*;
#(
  parameter int unsigned WIDTH    = 16,
  parameter ovf_mode_e   OVF_MODE = CNT_WRAP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             ovf_o
);

  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] CNT_ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] cnt_q, cnt_d, cnt_full_nxt;
  logic             ovf_q, ovf_d;
  logic             cnt_en;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);

  // Value taken by a full counter on a further event.
  generate
    if (OVF_MODE == CNT_SATURATE) begin : g_sat
      assign cnt_full_nxt = CNT_MAX;
    end else begin : g_wrap
      assign cnt_full_nxt = '0;
    end
  endgenerate

  assign cnt_en = clr_i | evt_i;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (clr_i) begin
      cnt_d = evt_i ? CNT_ONE : '0;
      ovf_d = 1'b0;
    end else if (evt_i) begin
      if (at_max) begin
        cnt_d = cnt_full_nxt;
        ovf_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

endmodule

// File: rtl/rx_miss_pack.sv
module rx_miss_pack
  import rx_miss_pkg::*;
#(
  parameter int unsigned MISS_W = 16,
  parameter int unsigned FOVF_W = 11
) (
  input  logic [MISS_W-1:0]   miss_cnt_i,
  input  logic                miss_ovf_i,
  input  logic [FOVF_W-1:0]   fovf_cnt_i,
  input  logic                fovf_ovf_i,
  output logic [STATUS_W-1:0] word_o
);

  localparam int unsigned MISS_FLAG = MISS_W;
  localparam int unsigned FOVF_LSB  = MISS_W + 1;
  localparam int unsigned FOVF_FLAG = FOVF_LSB + FOVF_W;

  generate
    if (used_bits(MISS_W, FOVF_W) > STATUS_W) begin : g_bad_layout
      initial $error("rx_miss_pack: fields do not fit the status word");
    end
  endgenerate

  always_comb begin
    word_o                           = '0;
    word_o[MISS_W-1:0]               = miss_cnt_i;
    word_o[MISS_FLAG]                = miss_ovf_i;
    word_o[FOVF_FLAG-1:FOVF_LSB]     = fovf_cnt_i;
    word_o[FOVF_FLAG]                = fovf_ovf_i;
  end

endmodule

// File: rtl/rx_miss_cnt.sv
module rx_miss_cnt
  import rx_miss_pkg::*;
#(
  parameter int unsigned MISS_W   = 16,
  parameter int unsigned FOVF_W   = 11,
  parameter ovf_mode_e   OVF_MODE = CNT_WRAP
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        miss_evt_i,
  input  logic        fovf_evt_i,
  input  logic        rd_i,
  output logic [31:0] status_o
);

  logic              rst_sync_n;
  logic [MISS_W-1:0] miss_cnt;
  logic              miss_ovf;
  logic [FOVF_W-1:0] fovf_cnt;
  logic              fovf_ovf;

  rx_miss_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rx_evt_counter #(.WIDTH(MISS_W), .OVF_MODE(OVF_MODE)) u_miss (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .evt_i (miss_evt_i),
    .clr_i (rd_i),
    .cnt_o (miss_cnt),
    .ovf_o (miss_ovf)
  );

  rx_evt_counter #(.WIDTH(FOVF_W), .OVF_MODE(OVF_MODE)) u_fovf (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .evt_i (fovf_evt_i),
    .clr_i (rd_i),
    .cnt_o (fovf_cnt),
    .ovf_o (fovf_ovf)
  );

  rx_miss_pack #(.MISS_W(MISS_W), .FOVF_W(FOVF_W)) u_pack (
    .miss_cnt_i (miss_cnt),
    .miss_ovf_i (miss_ovf),
    .fovf_cnt_i (fovf_cnt),
    .fovf_ovf_i (fovf_ovf),
    .word_o     (status_o)
  );

endmodule

// File: rtl/rx_miss_cnt_chk.sv
module rx_miss_cnt_chk
  import rx_miss_pkg::*;
#(
  parameter int unsigned MISS_W   = 16,
  parameter int unsigned FOVF_W   = 11,
  parameter ovf_mode_e   OVF_MODE = CNT_WRAP
) (
  input logic        clk,
  input logic        rst_n,
  input logic        miss_evt_i,
  input logic        fovf_evt_i,
  input logic        rd_i,
  input logic [31:0] status_o
);

  localparam int unsigned FOVF_LSB = MISS_W + 1;
  localparam int unsigned FOVF_FLG = FOVF_LSB + FOVF_W;
  localparam int unsigned USED     = FOVF_FLG + 1;
  localparam logic [MISS_W-1:0] M_MAX = {MISS_W{1'b1}};
  localparam logic [FOVF_W-1:0] F_MAX = {FOVF_W{1'b1}};

  logic [MISS_W-1:0] m_cnt;
  logic              m_flg;
  logic [FOVF_W-1:0] f_cnt;
  logic              f_flg;

  assign m_cnt = status_o[MISS_W-1:0];
  assign m_flg = status_o[MISS_W];
  assign f_cnt = status_o[FOVF_FLG-1:FOVF_LSB];
  assign f_flg = status_o[FOVF_FLG];

  AST_MISS_INCR: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i && miss_evt_i && m_cnt != M_MAX) |=> (m_cnt == MISS_W'($past(m_cnt) + 1'b1))); // R2

  AST_FOVF_INCR: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i && fovf_evt_i && f_cnt != F_MAX) |=> (f_cnt == FOVF_W'($past(f_cnt) + 1'b1))); // R3

  AST_MISS_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i && miss_evt_i && m_cnt == M_MAX) |=> m_flg); // R4

  AST_FOVF_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i && fovf_evt_i && f_cnt == F_MAX) |=> f_flg); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i && m_flg) |=> m_flg); // R4

  AST_FULL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i && miss_evt_i && m_cnt == M_MAX) |=>
      (m_cnt == ((OVF_MODE == CNT_SATURATE) ? M_MAX : '0))); // R5 R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !miss_evt_i && !fovf_evt_i) |=> (status_o == 32'd0)); // R7

  AST_EVT_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && miss_evt_i) |=> (m_cnt == MISS_W'(1) && !m_flg)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i && !miss_evt_i && !fovf_evt_i) |=> $stable(status_o)); // R4

  AST_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o >> USED) == 32'd0); // R9

endmodule

bind rx_miss_cnt rx_miss_cnt_chk #(
  .MISS_W   (MISS_W),
  .FOVF_W   (FOVF_W),
  .OVF_MODE (OVF_MODE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .miss_evt_i (miss_evt_i),
  .fovf_evt_i (fovf_evt_i),
  .rd_i       (rd_i),
  .status_o   (status_o)
);

// File: tb/rx_miss_cnt_test.sv
`timescale 1ns/1ps
module rx_miss_cnt_test;
  import rx_miss_pkg::*;

  logic clk;
  logic rst_n;
  logic miss, fovf, rd;
  logic s_miss, s_fovf, s_rd;
  logic [31:0] status, s_status;

  int unsigned n_checks;
  int unsigned n_fail;

  rx_miss_cnt uut (
    .clk(clk), .rst_n(rst_n), .miss_evt_i(miss), .fovf_evt_i(fovf),
    .rd_i(rd), .status_o(status)
  );

  rx_miss_cnt #(.MISS_W(4), .FOVF_W(3), .OVF_MODE(CNT_SATURATE)) uut_sat (
    .clk(clk), .rst_n(rst_n), .miss_evt_i(s_miss), .fovf_evt_i(s_fovf),
    .rd_i(s_rd), .status_o(s_status)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drive(input logic m, input logic f, input int unsigned n);
    miss = m; fovf = f;
    for (int i = 0; i < n; i++) tick();
    miss = 1'b0; fovf = 1'b0;
  endtask

  task automatic do_read(input string req, input logic [31:0] exp);
    rd = 1'b1;
    check(req, status, exp);
    tick();
    rd = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset", status, 32'd0);
    check("R1 reset sat", s_status, 32'd0);
  endtask

  task automatic t_miss_count();
    drive(1'b1, 1'b0, 5);
    check("R2 miss count", status, 32'd5);
    check("R9 top bits", {29'd0, status[31:29]}, 32'd0);
  endtask

  task automatic t_read_clear();
    do_read("R7 read value", 32'd5);
    check("R7 cleared", status, 32'd0);
  endtask

  task automatic t_fifo_count();
    drive(1'b0, 1'b1, 3);
    check("R3 fifo count", status, 32'd3 << 17);
    do_read("R7 read fifo", 32'd3 << 17);
    check("R7 fifo cleared", status, 32'd0);
  endtask

  task automatic t_both();
    drive(1'b1, 1'b1, 4);
    check("R10 both", status, (32'd4 << 17) | 32'd4);
    do_read("R10 read both", (32'd4 << 17) | 32'd4);
  endtask

  task automatic t_evt_in_read();
    drive(1'b1, 1'b0, 7);
    rd = 1'b1; miss = 1'b1; fovf = 1'b1;
    check("R8 value at read", status, 32'd7);
    tick();
    rd = 1'b0; miss = 1'b0; fovf = 1'b0;
    check("R8 event counted", status, (32'd1 << 17) | 32'd1);
    do_read("R8 clear again", (32'd1 << 17) | 32'd1);
  endtask

  task automatic t_fovf_wrap();
    drive(1'b0, 1'b1, 2047);
    check("R3 fifo full", status, 32'h7FF << 17);
    drive(1'b0, 1'b1, 1);
    check("R5 R4 fifo wrap flag", status, 32'd1 << 28);
    drive(1'b0, 1'b1, 1);
    check("R4 fifo sticky", status, (32'd1 << 28) | (32'd1 << 17));
    do_read("R7 read flag", (32'd1 << 28) | (32'd1 << 17));
    check("R7 flag cleared", status, 32'd0);
  endtask

  task automatic t_miss_wrap();
    drive(1'b1, 1'b0, 65535);
    check("R2 miss full", status, 32'h0000FFFF);
    drive(1'b1, 1'b0, 1);
    check("R5 R4 miss wrap flag", status, 32'd1 << 16);
    drive(1'b0, 1'b0, 3);
    check("R4 miss flag holds idle", status, 32'd1 << 16);
    do_read("R7 read miss flag", 32'd1 << 16);
    check("R7 miss flag cleared", status, 32'd0);
  endtask

  // Saturate instance layout: miss [3:0], flag 4, fifo [7:5], flag 8.
  task automatic t_saturate();
    s_miss = 1'b1;
    for (int i = 0; i < 15; i++) tick();
    s_miss = 1'b0;
    check("R6 sat full no flag", s_status, 32'h0000000F);
    s_miss = 1'b1; s_fovf = 1'b1;
    for (int i = 0; i < 12; i++) tick();
    s_miss = 1'b0; s_fovf = 1'b0;
    check("R6 sat held with flags", s_status, 32'h000001FF);
    s_rd = 1'b1;
    check("R7 sat read", s_status, 32'h000001FF);
    tick();
    s_rd = 1'b0;
    check("R7 sat cleared", s_status, 32'd0);
  endtask

  initial begin
    n_checks = 0; n_fail = 0;
    miss = 0; fovf = 0; rd = 0; s_miss = 0; s_fovf = 0; s_rd = 0;
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_miss_count();
    t_read_clear();
    t_fifo_count();
    t_both();
    t_evt_in_read();
    t_fovf_wrap();
    t_miss_wrap();
    t_saturate();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule